// File: doc/BRIEF.md
# SPI Target Byte Engine

This block is the serial front end of a SPI target. It watches the controller's clock, data-in and select pins and brings them into the system clock domain. For every byte the controller clocks it shifts one byte in from the data-in pin and one byte out on the data-out pin. Every transfer is full duplex, so a byte goes out in every slot even when the local side has nothing to say. Received bytes are presented as one-cycle strobes with their data. The outgoing byte is taken from a simple valid/take source at the start of each byte slot. If the source is empty, a programmable filler byte goes out instead.

The engine works in all four clock modes. Each direction has its own bit-order control. When select returns high, the engine raises a one-cycle event so that downstream storage can delimit frames. A byte that is only partly shifted when select rises is dropped. The pins are oversampled, so the serial clock must stay at each level for at least four system clock cycles.

The control is a three-state machine:
- ST_IDLE: select is inactive and the output pin is held low.
- ST_LOAD: one cycle in which the outgoing byte is fetched.
- ST_SHIFT: bits are exchanged.

The transitions are:
- IDLE→LOAD when select falls.
- LOAD→SHIFT on the next cycle.
- SHIFT→LOAD after the eighth sample edge.
- LOAD or SHIFT→IDLE whenever select is high.

Top module: `spi_tgt_engine`

## Requirements
- R1: After reset, spi_miso, rx_valid, tx_take and cs_rise are 0, and the filler byte is 0xFF.
- R2: Each group of eight sample edges inside one select-low period produces exactly one rx_valid pulse of one cycle. With cfg_rx_msb_first=1 the first bit on the wire lands in rx_data bit 7. With 0 it lands in bit 0.
- R3: With cfg_tx_msb_first=1 bit 7 of the outgoing byte is the first bit on spi_miso. With 0, bit 0 is first.
- R4: cfg_mode bit 1 is the clock idle level and bit 0 is the phase. With phase 0, data is sampled on the edge leaving idle, and the first output bit is valid before that edge. With phase 1, output changes on the edge leaving idle and data is sampled on the edge returning to idle. All four modes work.
- R5: At the start of each byte slot with tx_valid high, tx_take pulses for exactly one cycle and tx_data becomes the byte sent in that slot.
- R6: At the start of a byte slot with tx_valid low, the filler byte is sent and tx_take stays low. A cycle with dummy_we high loads dummy_wdata as the new filler byte.
- R7: Each rise of spi_cs_n produces exactly one cs_rise pulse, one cycle wide.
- R8: A byte cut short by select rising yields no rx_valid, and the next transfer starts again at bit 0.
- R9: While spi_cs_n is high, spi_miso is 0 and clock edges produce no received bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Clock mode: bit 1 idle level, bit 0 phase |
| cfg_rx_msb_first | input | 1 | 1: first received bit is the byte MSB |
| cfg_tx_msb_first | input | 1 | 1: first sent bit is the byte MSB |
| dummy_we | input | 1 | Load strobe for the filler byte |
| dummy_wdata | input | DATA_W | New filler byte value |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to the controller |
| tx_valid | input | 1 | An outgoing byte is available |
| tx_data | input | DATA_W | Outgoing byte |
| tx_take | output | 1 | One-cycle pulse: tx_data consumed |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new byte |
| rx_data | output | DATA_W | Last received byte |
| cs_rise | output | 1 | One-cycle pulse on select deassertion |

## Verification
The hardest situation to reach is the slot boundary inside a long select-low period, with the next byte either queued or missing. At that point the fetch, the bit-index reset and the phase-0 first-bit presentation all happen between two serial edges. The bench reaches it with a three-byte transfer whose source holds only two bytes, so the third slot falls back to the filler byte. It also aborts a transfer after three bits to prove that the bit counter restarts. All four clock modes are run with mixed bit orders.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } tgt_state_e;

    localparam int MODE_CPOL_BIT = 1;
    localparam int MODE_CPHA_BIT = 0;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RESET_VAL;
            end
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_ev,
    output logic shift_ev
);

    logic sclk_q;
    logic rise;
    logic fall;
    logic leading;
    logic trailing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
        end
    end

    always_comb begin
        rise      = sclk_s & ~sclk_q;
        fall      = ~sclk_s & sclk_q;
        leading   = cpol ? fall : rise;
        trailing  = cpol ? rise : fall;
        sample_ev = cpha ? trailing : leading;
        shift_ev  = cpha ? leading : trailing;
    end

endmodule

// File: rtl/spi_tgt_fsm.sv
module spi_tgt_fsm
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              mosi_s,
    input  logic              sample_ev,
    input  logic              shift_ev,
    input  logic              rx_msb_first,
    input  logic              tx_msb_first,
    input  logic              dummy_we,
    input  logic [DATA_W-1:0] dummy_wdata,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic              tx_take,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              cs_rise
);

    localparam int               IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DATA_W - 1);

    tgt_state_e        state_q;
    tgt_state_e        state_d;
    logic [DATA_W-1:0] rx_sh_q;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] dummy_q;
    logic [DATA_W-1:0] rx_data_q;
    logic [IDX_W-1:0]  rx_cnt_q;
    logic [IDX_W-1:0]  tx_idx_q;
    logic [IDX_W-1:0]  tx_pos;
    logic              rx_valid_q;
    logic              cs_q;
    logic              cs_rise_q;
    logic              take_bit;
    logic              byte_done;

    // received-bit insertion point follows the rx bit order
    always_comb begin
        if (rx_msb_first) begin
            rx_next = {rx_sh_q[DATA_W-2:0], mosi_s};
        end else begin
            rx_next = {mosi_s, rx_sh_q[DATA_W-1:1]};
        end
        take_bit  = (state_q == ST_SHIFT) && !cs_s && sample_ev;
        byte_done = take_bit && (rx_cnt_q == LAST);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_s) state_d = ST_LOAD;
            ST_LOAD:  state_d = cs_s ? ST_IDLE : ST_SHIFT;
            ST_SHIFT: begin
                if (cs_s) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    state_d = ST_LOAD;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            dummy_q    <= '1;
            rx_data_q  <= '0;
            rx_cnt_q   <= '0;
            tx_idx_q   <= '0;
            rx_valid_q <= 1'b0;
            cs_q       <= 1'b1;
            cs_rise_q  <= 1'b0;
        end else begin
            cs_q       <= cs_s;
            cs_rise_q  <= cs_s & ~cs_q;
            rx_valid_q <= 1'b0;
            if (dummy_we) begin
                dummy_q <= dummy_wdata;
            end
            unique case (state_q)
                ST_IDLE: begin
                    rx_cnt_q <= '0;
                    tx_idx_q <= '0;
                end
                ST_LOAD: begin
                    tx_sh_q  <= tx_valid ? tx_data : dummy_q;
                    rx_cnt_q <= '0;
                    tx_idx_q <= '0;
                end
                ST_SHIFT: begin
                    if (take_bit) begin
                        rx_sh_q  <= rx_next;
                        rx_cnt_q <= byte_done ? '0 : rx_cnt_q + 1'b1;
                        if (byte_done) begin
                            rx_data_q  <= rx_next;
                            rx_valid_q <= 1'b1;
                        end
                    end
                    if (shift_ev && !cs_s) begin
                        tx_idx_q <= rx_cnt_q;
                    end
                end
                default: begin
                    rx_cnt_q <= '0;
                    tx_idx_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_pos   = tx_msb_first ? (LAST - tx_idx_q) : tx_idx_q;
        miso     = (state_q == ST_SHIFT) ? tx_sh_q[tx_pos] : 1'b0;
        tx_take  = (state_q == ST_LOAD) && !cs_s && tx_valid;
        rx_valid = rx_valid_q;
        rx_data  = rx_data_q;
        cs_rise  = cs_rise_q;
    end

endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_rx_msb_first,
    input  logic              cfg_tx_msb_first,
    input  logic              dummy_we,
    input  logic [DATA_W-1:0] dummy_wdata,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_take,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              cs_rise
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             sclk_s;
    logic             mosi_s;
    logic             cs_s;
    logic             sample_ev;
    logic             shift_ev;

    spi_tgt_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_mosi, spi_sclk}),
        .dout  (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign mosi_s = pins_s[1];
    assign cs_s   = pins_s[2];

    spi_tgt_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cpol      (cfg_mode[MODE_CPOL_BIT]),
        .cpha      (cfg_mode[MODE_CPHA_BIT]),
        .sample_ev (sample_ev),
        .shift_ev  (shift_ev)
    );

    spi_tgt_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_s         (cs_s),
        .mosi_s       (mosi_s),
        .sample_ev    (sample_ev),
        .shift_ev     (shift_ev),
        .rx_msb_first (cfg_rx_msb_first),
        .tx_msb_first (cfg_tx_msb_first),
        .dummy_we     (dummy_we),
        .dummy_wdata  (dummy_wdata),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .miso         (spi_miso),
        .tx_take      (tx_take),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .cs_rise      (cs_rise)
    );

endmodule

// File: rtl/spi_tgt_engine_chk.sv
module spi_tgt_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sample_ev,
    input logic spi_miso,
    input logic rx_valid,
    input logic tx_take,
    input logic cs_rise
);

    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2

    AST_RXV_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sample_ev)); // R2

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take); // R5

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !cs_rise); // R7

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !spi_miso); // R9

    AST_NO_RX_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !rx_valid); // R8

endmodule

bind spi_tgt_engine spi_tgt_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sample_ev (sample_ev),
    .spi_miso  (spi_miso),
    .rx_valid  (rx_valid),
    .tx_take   (tx_take),
    .cs_rise   (cs_rise)
);

// File: tb/spi_tgt_engine_tb.sv
`timescale 1ns/1ps
module spi_tgt_engine_tb;

    localparam int H = 8;
    localparam int NVEC = 8;
    // {mode[1:0], rx_msb, tx_msb, mosi_byte[7:0], tx_byte[7:0], tx_avail}
    localparam logic [20:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b1},
        {2'd1, 1'b1, 1'b1, 8'h96, 8'hC3, 1'b1},
        {2'd2, 1'b1, 1'b1, 8'h5B, 8'hE7, 1'b1},
        {2'd3, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b1},
        {2'd0, 1'b0, 1'b1, 8'h12, 8'h34, 1'b1},
        {2'd3, 1'b1, 1'b0, 8'hC8, 8'h1F, 1'b1},
        {2'd1, 1'b0, 1'b0, 8'h6D, 8'hB2, 1'b1},
        {2'd2, 1'b1, 1'b1, 8'h44, 8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_rx_msb_first = 1'b1;
    logic       cfg_tx_msb_first = 1'b1;
    logic       dummy_we = 1'b0;
    logic [7:0] dummy_wdata = 8'h00;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_miso;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_take;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       cs_rise;

    logic [7:0] txq [8];
    int         q_len = 0;
    int         q_rd;
    logic       clr = 1'b0;
    logic [7:0] cap [16];
    int         rx_n, rise_n, take_n, rise_dbl;
    logic       rise_prev;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       done = 1'b0;
    logic [7:0] dummy_model = 8'hFF;

    always #5 clk = ~clk;

    spi_tgt_engine u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_mode         (cfg_mode),
        .cfg_rx_msb_first (cfg_rx_msb_first),
        .cfg_tx_msb_first (cfg_tx_msb_first),
        .dummy_we         (dummy_we),
        .dummy_wdata      (dummy_wdata),
        .spi_sclk         (spi_sclk),
        .spi_mosi         (spi_mosi),
        .spi_cs_n         (spi_cs_n),
        .spi_miso         (spi_miso),
        .tx_valid         (tx_valid),
        .tx_data          (tx_data),
        .tx_take          (tx_take),
        .rx_valid         (rx_valid),
        .rx_data          (rx_data),
        .cs_rise          (cs_rise)
    );

    assign tx_valid = (q_rd < q_len);
    assign tx_data  = txq[q_rd[2:0]];

    always @(posedge clk) begin
        if (clr) begin
            q_rd     <= 0;
            rx_n     <= 0;
            rise_n   <= 0;
            take_n   <= 0;
            rise_dbl <= 0;
        end else begin
            if (tx_take) begin
                q_rd   <= q_rd + 1;
                take_n <= take_n + 1;
            end
            if (rx_valid) begin
                cap[rx_n[3:0]] <= rx_data;
                rx_n <= rx_n + 1;
            end
            if (cs_rise) rise_n <= rise_n + 1;
            if (cs_rise && rise_prev) rise_dbl <= rise_dbl + 1;
        end
        rise_prev <= cs_rise;
    end

    function automatic logic [7:0] rev8(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr = 1'b1;
        q_len = 0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic cs_on();
        spi_sclk = cfg_mode[1];
        wait_clk(5);
        spi_cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_off();
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic spi_bits(input logic [7:0] mo, input int nb, output logic [7:0] mi);
        mi = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            if (!cfg_mode[0]) begin
                spi_mosi = mo[i];
                wait_clk(H);
                spi_sclk = ~cfg_mode[1];
                mi = {mi[6:0], spi_miso};
                wait_clk(H);
                spi_sclk = cfg_mode[1];
            end else begin
                spi_sclk = ~cfg_mode[1];
                spi_mosi = mo[i];
                wait_clk(H);
                spi_sclk = cfg_mode[1];
                mi = {mi[6:0], spi_miso};
                wait_clk(H);
            end
        end
    endtask

    initial begin
        logic [7:0] mi;
        logic [7:0] txe;
        wait_clk(3);
        rst_n = 1'b1;
        clear_all();
        wait_clk(2);
        // R1 reset state
        check("R1 miso", spi_miso, 0);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 tx_take", tx_take, 0);
        check("R1 cs_rise", cs_rise, 0);

        for (int v = 0; v < NVEC; v++) begin
            clear_all();
            cfg_mode         = VEC[v][20:19];
            cfg_rx_msb_first = VEC[v][18];
            cfg_tx_msb_first = VEC[v][17];
            txq[0]           = VEC[v][8:1];
            q_len            = VEC[v][0] ? 1 : 0;
            txe              = VEC[v][0] ? VEC[v][8:1] : dummy_model;
            cs_on();
            spi_bits(VEC[v][16:9], 8, mi);
            cs_off();
            check("R2 rx count", rx_n, 1);
            check("R2 rx byte", cap[0], VEC[v][18] ? VEC[v][16:9] : rev8(VEC[v][16:9]));
            check("R3 R4 miso byte", mi, VEC[v][17] ? txe : rev8(txe));
            check(VEC[v][0] ? "R5 take count" : "R6 R1 no take", take_n, VEC[v][0] ? 1 : 0);
            check("R7 rise count", rise_n, 1);
            check("R7 rise width", rise_dbl, 0);
        end

        // R6 programmable filler byte
        @(negedge clk);
        dummy_we = 1'b1;
        dummy_wdata = 8'h5A;
        @(negedge clk);
        dummy_we = 1'b0;
        dummy_model = 8'h5A;
        clear_all();
        cfg_mode = 2'd0; cfg_rx_msb_first = 1'b1; cfg_tx_msb_first = 1'b1;
        cs_on();
        spi_bits(8'h0F, 8, mi);
        cs_off();
        check("R6 filler byte", mi, 8'h5A);
        check("R6 no take", take_n, 0);

        // multi-byte frame: two queued bytes, third slot empty
        clear_all();
        cfg_mode = 2'd1;
        txq[0] = 8'h11; txq[1] = 8'h22; q_len = 2;
        cs_on();
        spi_bits(8'hAA, 8, mi);
        check("R5 slot0 miso", mi, 8'h11);
        spi_bits(8'hBB, 8, mi);
        check("R5 slot1 miso", mi, 8'h22);
        spi_bits(8'hCC, 8, mi);
        check("R6 slot2 filler", mi, 8'h5A);
        cs_off();
        check("R2 rx count 3", rx_n, 3);
        check("R2 rx b0", cap[0], 8'hAA);
        check("R2 rx b1", cap[1], 8'hBB);
        check("R2 rx b2", cap[2], 8'hCC);
        check("R5 take 2", take_n, 2);
        check("R7 one rise", rise_n, 1);

        // R8 partial byte discarded, counter restarts
        clear_all();
        cfg_mode = 2'd0;
        cs_on();
        spi_bits(8'hE0, 3, mi);
        cs_off();
        check("R8 partial no rx", rx_n, 0);
        check("R7 partial rise", rise_n, 1);
        cs_on();
        spi_bits(8'hF0, 8, mi);
        cs_off();
        check("R8 restart rx count", rx_n, 1);
        check("R8 restart rx byte", cap[0], 8'hF0);

        // R9 clock activity while deselected
        clear_all();
        for (int k = 0; k < 12; k++) begin
            spi_mosi = k[0];
            spi_sclk = ~spi_sclk;
            wait_clk(H);
            check("R9 miso idle", spi_miso, 0);
        end
        check("R9 no rx deselected", rx_n, 0);
        check("R9 no take deselected", take_n, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule